// File: doc/BRIEF.md
# USB Controller Interrupt Status and Mask Unit

This block collects interrupt causes for a USB host or device controller. Single-cycle event strobes from the neighbouring engines set sticky status bits. Software reads those bits over a small register bus and clears each one by writing a one to it. A per-cause mask and one global enable decide whether the single interrupt request line goes high. The same line drops once software has cleared every pending cause that the mask allows through, or once software clears the global enable.

The frame-overflow cause comes from watching the most significant bit of the frame counter: any change of that bit, rising or falling, records a cause. Software can raise its own interrupt by writing to a request register. The fatal bus-error cause is recorded only while the controller runs in host mode. Bit 31 of the status word is a read-only summary: it is high whenever some pending cause is also unmasked.

The register bus takes a word address. Word 0 (byte offset 0x00) is the software request register. Word 1 (0x04) is the status register. Word 2 (0x08) is the mask/enable register. Word 3 (0x0C) is reserved. Read data is registered: `bus_rdata` shows the register that was addressed at the previous clock edge.

Top module: `usb_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every status bit, all mask bits, the global enable and `irq_o`.
- R2: Writing the status register clears each status bit whose write-data bit is one and leaves every bit written with zero unchanged.
- R3: If an event strobe and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R4: Status bit 0 latches on `ev_port_chg`, bit 10 latches on `ev_sched_ovr`, and bit 20 latches on `ev_td_done`.
- R5: Status bit 11 latches in the cycle after `frame_msb` changes value, for both rising and falling changes.
- R6: Writing a one to bit 0 of word 0 sets status bit 29. Word 0 always reads as zero.
- R7: `ev_bus_fatal` sets status bit 30 only while `host_mode` is 1. While `host_mode` is 0, bit 30 reads zero.
- R8: Status bit 31 reads one exactly when some status bit in 30:0 is set and its mask bit is also set. Writes to bit 31 have no effect.
- R9: Word 2 holds the mask in bits 30:0 (a one lets the cause through) and the global enable in bit 31. It reads back what was written.
- R10: `irq_o` is a registered level. It is high one cycle after the global enable and the summary are both high, and it is low one cycle after either of them is low.
- R11: Status bits other than 0, 10, 11, 20, 29 and 30 always read zero, including after ones are written to them. Word 3 reads zero.
- R12: `bus_rdata` presents the register addressed at the previous rising edge, as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | 1 = host mode, 0 = device mode |
| ev_port_chg | input | 1 | Port connect/disconnect strobe |
| ev_sched_ovr | input | 1 | Schedule overrun strobe |
| ev_td_done | input | 1 | Transfer descriptor completion strobe |
| ev_bus_fatal | input | 1 | Fatal system-bus error strobe |
| frame_msb | input | 1 | Most significant bit of the frame counter |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request level |

## Verification
The bench drives a strobe and a clear onto the same bit in the same cycle. A design that lets the clear win would silently drop a schedule-overrun event. It toggles the frame MSB in both directions; a detector that only sees rising changes would miss the falling one. It writes one to the summary bit and to reserved positions, where a careless decode would latch bits that must stay zero. It also sends a fatal strobe in device mode, where a missing mode gate would set bit 30. Finally it clears the global enable while a cause is still pending, and a combinational or sticky request line would then stay high.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CAUSE_W   = 31;
  localparam int B_PORT    = 0;
  localparam int B_OVR     = 10;
  localparam int B_FRAME   = 11;
  localparam int B_TD      = 20;
  localparam int B_SW      = 29;
  localparam int B_FATAL   = 30;
  localparam int SWREQ_BIT = 0;

  localparam logic [CAUSE_W-1:0] CAUSE_IMPL =
      (CAUSE_W'(1) << B_PORT) | (CAUSE_W'(1) << B_OVR) | (CAUSE_W'(1) << B_FRAME) |
      (CAUSE_W'(1) << B_TD)   | (CAUSE_W'(1) << B_SW)  | (CAUSE_W'(1) << B_FATAL);

  typedef enum logic [1:0] {
    W_SWREQ = 2'd0,
    W_STAT  = 2'd1,
    W_ENA   = 2'd2,
    W_RSVD  = 2'd3
  } reg_word_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int              W    = 31,
  parameter logic [W-1:0]    IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] set_eff;
  assign set_eff = set_i & IMPL;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst)             q <= 1'b0;
      else if (set_eff[i]) q <= 1'b1;
      else if (clr_i[i])   q <= 1'b0;
    end
    assign stat_o[i] = q;

    p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
      set_eff[i] |=> stat_o[i]) else $error("set lost on bit %0d", i);
    p_w1c_r2: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_eff[i]) |=> !stat_o[i]) else $error("clear failed bit %0d", i);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (!clr_i[i] && !set_eff[i]) |=> $stable(stat_o[i])) else $error("bit %0d moved", i);
  end

  always_comb begin
    p_rsvd_zero_r11: assert ((stat_o & ~IMPL) == '0) else $error("reserved status bit set");
  end
endmodule

// File: rtl/irq_msb_watch.sv
module irq_msb_watch (
  input  logic clk,
  input  logic rst,
  input  logic msb_i,
  output logic flip_o
);
  logic prev_q;
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= msb_i;
  end
  assign flip_o = msb_i ^ prev_q;
endmodule

// File: rtl/irq_req_out.sv
module irq_req_out #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  input  logic         en_i,
  output logic         active_o,
  output logic         irq_o
);
  assign active_o = |(stat_i & mask_i);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= en_i & active_o;
  end

  p_irq_off_r10: assert property (@(posedge clk) disable iff (rst)
    (!en_i || !active_o) |=> !irq_o) else $error("irq stuck high");
  p_irq_on_r10: assert property (@(posedge clk) disable iff (rst)
    (en_i && active_o) |=> irq_o) else $error("irq not raised");
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_mode,
  input  logic              ev_port_chg,
  input  logic              ev_sched_ovr,
  input  logic              ev_td_done,
  input  logic              ev_bus_fatal,
  input  logic              frame_msb,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int MW = DATA_W - 1;

  logic [MW-1:0] mask_q;
  logic          en_q;
  logic [MW-1:0] stat, set_v, clr_v;
  logic          frame_flip, active;
  logic          hit_swreq, hit_stat, hit_ena;

  assign hit_swreq = (bus_addr == ADDR_W'(W_SWREQ));
  assign hit_stat  = (bus_addr == ADDR_W'(W_STAT));
  assign hit_ena   = (bus_addr == ADDR_W'(W_ENA));

  irq_msb_watch u_msb (
    .clk(clk), .rst(rst), .msb_i(frame_msb), .flip_o(frame_flip)
  );

  always_comb begin
    set_v          = '0;
    set_v[B_PORT]  = ev_port_chg;
    set_v[B_OVR]   = ev_sched_ovr;
    set_v[B_FRAME] = frame_flip;
    set_v[B_TD]    = ev_td_done;
    set_v[B_SW]    = bus_wr & hit_swreq & bus_wdata[SWREQ_BIT];
    set_v[B_FATAL] = ev_bus_fatal & host_mode;
    clr_v          = (bus_wr && hit_stat) ? bus_wdata[MW-1:0] : '0;
    clr_v[B_FATAL] = clr_v[B_FATAL] | ~host_mode;
  end

  irq_status_bank #(.W(MW), .IMPL(CAUSE_IMPL)) u_bank (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v), .stat_o(stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else if (bus_wr && hit_ena) begin
      mask_q <= bus_wdata[MW-1:0];
      en_q   <= bus_wdata[MW];
    end
  end

  irq_req_out #(.W(MW)) u_req (
    .clk(clk), .rst(rst), .stat_i(stat), .mask_i(mask_q), .en_i(en_q),
    .active_o(active), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)           bus_rdata <= '0;
    else if (hit_stat) bus_rdata <= {active, stat};
    else if (hit_ena)  bus_rdata <= {en_q, mask_q};
    else               bus_rdata <= '0;
  end

  p_frame_flip_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_msb != $past(frame_msb)) |-> ##1 stat[B_FRAME]) else $error("frame cause lost");
  p_fatal_dev_r7: assert property (@(posedge clk) disable iff (rst)
    !host_mode |=> !stat[B_FATAL]) else $error("fatal set in device mode");
  p_sw_req_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit_swreq && bus_wdata[SWREQ_BIT]) |=> stat[B_SW]) else $error("sw request lost");
  p_ena_read_r12: assert property (@(posedge clk) disable iff (rst)
    (hit_ena && !bus_wr) |=> (bus_rdata == {en_q, mask_q})) else $error("enable readback");
endmodule

// File: tb/usb_irq_ctrl_tb_top.sv
module usb_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_mode = 1'b1;
  logic ev_port_chg = 0, ev_sched_ovr = 0, ev_td_done = 0, ev_bus_fatal = 0;
  logic frame_msb = 0;
  logic bus_wr = 0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usb_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .host_mode(host_mode),
    .ev_port_chg(ev_port_chg), .ev_sched_ovr(ev_sched_ovr),
    .ev_td_done(ev_td_done), .ev_bus_fatal(ev_bus_fatal),
    .frame_msb(frame_msb), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        fatal, td, ovr, port, msb;
    logic [31:0] clr;
    logic [31:0] exp_st;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 32'h0000_0000, 32'h8000_0001, 1'b1}, // R4 port
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_0001, 32'h0000_0000, 1'b0}, // R2 clear
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 32'h0000_0000, 32'h0010_0000, 1'b0}, // R4 td masked, R8
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 32'h0000_0000, 32'h8010_0400, 1'b1}, // R4 overrun
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 32'h0000_0000, 32'h8010_0400, 1'b1}, // R4 td again
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0000_0000, 32'h8010_0C00, 1'b1}, // R5 rise
    '{1'b0,1'b0,1'b1,1'b0,1'b1, 32'h0000_0400, 32'h8010_0C00, 1'b1}, // R3 set wins
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0010_0C00, 32'h0000_0000, 1'b0}, // R2 multi clear
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_0000, 32'h8000_0800, 1'b1}, // R5 fall
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_0000, 32'h8000_0800, 1'b1}, // R8 bit31 write
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 32'h7FFF_F7FF, 32'h8000_0800, 1'b1}, // R2 R11 zeros keep
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0000_0000, 32'hC000_0800, 1'b1}, // R7 host fatal
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 32'h4000_0800, 32'h0000_0000, 1'b0}  // R2 clear all
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse_port();
    @(negedge clk); ev_port_chg = 1'b1;
    @(negedge clk); ev_port_chg = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(2'd1, d); chk("R1 status", d, 32'h0);
    rd(2'd2, d); chk("R1 enable", d, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    // R9 enable readback, R11 reserved word
    wr(2'd2, 32'hE000_0C01);
    rd(2'd2, d); chk("R9 readback", d, 32'hE000_0C01);
    rd(2'd3, d); chk("R11 word3", d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ev_bus_fatal = VEC[i].fatal; ev_td_done = VEC[i].td;
      ev_sched_ovr = VEC[i].ovr;   ev_port_chg = VEC[i].port;
      frame_msb    = VEC[i].msb;
      if (VEC[i].clr != 32'h0) begin
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = VEC[i].clr;
      end
      @(negedge clk);
      ev_bus_fatal = 0; ev_td_done = 0; ev_sched_ovr = 0; ev_port_chg = 0;
      bus_wr = 1'b0; bus_wdata = '0; bus_addr = 2'd1;
      @(negedge clk);
      chk($sformatf("R12 vec%0d status", i), bus_rdata, VEC[i].exp_st);
      chk($sformatf("R10 vec%0d irq", i), {31'b0, irq_o}, {31'b0, VEC[i].exp_irq});
    end

    // R6 software request
    wr(2'd0, 32'h0000_0001);
    rd(2'd1, d); chk("R6 sw status", d, 32'hA000_0000);
    chk("R6 sw irq", {31'b0, irq_o}, 32'h1);
    rd(2'd0, d); chk("R6 word0 reads zero", d, 32'h0);
    wr(2'd1, 32'h2000_0000);
    rd(2'd1, d); chk("R2 sw cleared", d, 32'h0);

    // R10 global enable off with cause pending
    pulse_port();
    rd(2'd1, d); chk("R4 port again", d, 32'h8000_0001);
    wr(2'd2, 32'h6000_0C01);
    rd(2'd1, d); chk("R8 summary stays", d, 32'h8000_0001);
    chk("R10 irq drops on disable", {31'b0, irq_o}, 32'h0);
    // R8 mask off removes summary
    wr(2'd2, 32'h8000_0000);
    rd(2'd1, d); chk("R8 masked summary", d, 32'h0000_0001);
    chk("R10 irq masked", {31'b0, irq_o}, 32'h0);
    wr(2'd1, 32'h0000_0001);

    // R7 device mode fatal ignored
    host_mode = 1'b0;
    @(negedge clk); ev_bus_fatal = 1'b1;
    @(negedge clk); ev_bus_fatal = 1'b0;
    rd(2'd1, d); chk("R7 device fatal", d, 32'h0);

    done = 1;
    finish_run();
  end
endmodule